// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-purpose register instructions of a small 32-bit RISC core. Each request presents a 16-bit register address, write data, a read/write select and the current value of the destination general register. The address is a group number in bits 15:11 and a register index in bits 10:0. For reads, the block returns the selected register combinationally. For writes, it updates the register and applies that register's side effects on the next clock edge.

The unit holds the supervision register, the next, previous and exception program counters, the exception address and status registers, a writable version register, and four read-only configuration words. It also holds way 0 of the data and instruction TLBs, split into match and translate arrays, and the interrupt-controller mask and pending-status registers. When a write changes translation state, the block sends the memory-management unit a one-cycle flush request. The request asks either for a full flush or for a flush of one page.

Top module: `spr_access_unit`

## Requirements
- R1: Address = group·2048 + index. Group 0 holds version (0), unit-present (1), CPU configuration (2), data-MMU configuration (3), instruction-MMU configuration (4), next PC (16), supervision (17), previous PC (18), exception PC (32), exception address (48) and exception status (64). The four configuration words are read-only: writes to them are ignored, and reads return the parameter values. The other registers read back what was last written.
- R2: A version read returns the stored value ANDed with the version field mask, bits 31:24 by default.
- R3: Every supervision write stores the written value with bit 15 forced to 1.
- R4: A supervision write whose bit 0 (supervisor mode), bit 5 (data MMU enable) or bit 6 (instruction MMU enable) differs from the stored value requests a full flush. A write that leaves all three bits unchanged requests no flush.
- R5: TLB way-0 entries are addressed by the low index bits. The entries are: data match at group 1, index 512+n; data translate at group 1, index 640+n; instruction match at group 2, index 512+n; instruction translate at group 2, index 640+n. Each of the four arrays is separate and reads back its own stored value.
- R6: Writing a match entry with bit 0 clear requests a single-page flush. The page number is bits 31:13 of the value the entry held before the write.
- R7: Indices 768 to 1535 in groups 1 and 2 accept writes without changing any state, and reads of them return the request's destination value.
- R8: A write to the interrupt mask (group 9, index 0) ORs the data into the mask, so writes never clear mask bits.
- R9: A write to interrupt status (group 9, index 2) clears the bits written as 1. Bits raised on the pending-set input in the same cycle stay set.
- R10: A read of any other address returns the request's destination value unchanged.
- R11: A flush request appears the clock edge after the write and lasts exactly one cycle. The flush_all output high means full flush and low means single page.
- R12: Reset gives supervision 0x00008001, version 0x12000000, and zero in every other stored register and TLB entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_addr | input | 16 | Register address, group in 15:11 |
| req_wdata | input | 32 | Write data |
| req_rd | input | 32 | Current destination register value |
| irq_set | input | 32 | Pending interrupt bits to set in status |
| rd_data | output | 32 | Read result |
| flush_valid | output | 1 | One-cycle flush request |
| flush_all | output | 1 | 1 = full flush, 0 = page flush |
| flush_page | output | 19 | Page number for a page flush |

## Verification
Supervision writes are tried in three forms. The first changes only the forced bit, the second changes several mode bits, and the third changes supervisor mode alone. Together they separate the no-flush case from a full flush and show that bit 15 is forced. Match writes are tried with the valid bit set and with it clear, on both TLBs. This shows that a flush fires only on invalidation and that it carries the old page rather than the new one. Reads of way 1 to 3 addresses and of unknown groups are given a distinctive destination value, which shows pass-through rather than zero. Repeated mask and status writes, including one that collides with a pending set, tell OR-in, clear-on-one and set priority apart.

// File: rtl/spr_access_unit.sv
module spr_access_unit #(
  parameter int          DW           = 32,
  parameter int          TLB_ENTRIES  = 128,
  parameter int          PAGE_SHIFT   = 13,
  parameter logic [31:0] VER_MASK     = 32'hFF00_0000,
  parameter logic [31:0] VER_RESET    = 32'h1200_0000,
  parameter logic [31:0] UNIT_PRESENT = 32'h0000_0019,
  parameter logic [31:0] CPU_CFG      = 32'h0000_0020,
  parameter logic [31:0] DMMU_CFG     = 32'h0000_001A,
  parameter logic [31:0] IMMU_CFG     = 32'h0000_001C,
  parameter logic [31:0] SR_RESET     = 32'h0000_8001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic [15:0]          req_addr,
  input  logic [DW-1:0]        req_wdata,
  input  logic [DW-1:0]        req_rd,
  input  logic [DW-1:0]        irq_set,
  output logic [DW-1:0]        rd_data,
  output logic                 flush_valid,
  output logic                 flush_all,
  output logic [DW-PAGE_SHIFT-1:0] flush_page
);
  localparam int IW = $clog2(TLB_ENTRIES);
  localparam int SM = 0, DME = 5, IME = 6, FO = 15;
  localparam logic [DW-1:0] MODE_MASK = DW'((1 << SM) | (1 << DME) | (1 << IME));
  localparam int MATCH_BASE = 512, XLATE_BASE = 640;

  function automatic logic [15:0] spr(input int g, input int i);
    return 16'((g << 11) + i);
  endfunction

  logic [4:0]  grp;
  logic [10:0] idx;
  logic [IW-1:0] ent;
  assign grp = req_addr[15:11];
  assign idx = req_addr[10:0];
  assign ent = req_addr[IW-1:0];

  function automatic logic in_arr(input logic [4:0] g_req, input int g, input logic [10:0] i, input int base);
    return (g_req == 5'(g)) && (int'(i) >= base) && (int'(i) < base + TLB_ENTRIES);
  endfunction

  logic sel_dmr, sel_dtr, sel_imr, sel_itr, wr;
  assign sel_dmr = in_arr(grp, 1, idx, MATCH_BASE);
  assign sel_dtr = in_arr(grp, 1, idx, XLATE_BASE);
  assign sel_imr = in_arr(grp, 2, idx, MATCH_BASE);
  assign sel_itr = in_arr(grp, 2, idx, XLATE_BASE);
  assign wr = req_valid & req_we;

  logic [DW-1:0] vr_q, npc_q, sr_q, ppc_q, epc_q, eear_q, esr_q, pmask_q, pstat_q;
  logic [DW-1:0] dmr_q [TLB_ENTRIES];
  logic [DW-1:0] dtr_q [TLB_ENTRIES];
  logic [DW-1:0] imr_q [TLB_ENTRIES];
  logic [DW-1:0] itr_q [TLB_ENTRIES];

  logic sel_sr, sel_pmask, sel_pstat;
  assign sel_sr    = req_addr == spr(0, 17);
  assign sel_pmask = req_addr == spr(9, 0);
  assign sel_pstat = req_addr == spr(9, 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vr_q <= VER_RESET; sr_q <= SR_RESET;
      npc_q <= '0; ppc_q <= '0; epc_q <= '0; eear_q <= '0; esr_q <= '0;
      pmask_q <= '0; pstat_q <= '0;
      for (int k = 0; k < TLB_ENTRIES; k++) begin
        dmr_q[k] <= '0; dtr_q[k] <= '0; imr_q[k] <= '0; itr_q[k] <= '0;
      end
    end else begin
      pstat_q <= (pstat_q & ~((wr && sel_pstat) ? req_wdata : '0)) | irq_set;
      if (wr) begin
        if (req_addr == spr(0, 0))  vr_q   <= req_wdata;
        if (req_addr == spr(0, 16)) npc_q  <= req_wdata;
        if (sel_sr)                 sr_q   <= req_wdata | DW'(1 << FO);
        if (req_addr == spr(0, 18)) ppc_q  <= req_wdata;
        if (req_addr == spr(0, 32)) epc_q  <= req_wdata;
        if (req_addr == spr(0, 48)) eear_q <= req_wdata;
        if (req_addr == spr(0, 64)) esr_q  <= req_wdata;
        if (sel_pmask)              pmask_q <= pmask_q | req_wdata;
        if (sel_dmr) dmr_q[ent] <= req_wdata;
        if (sel_dtr) dtr_q[ent] <= req_wdata;
        if (sel_imr) imr_q[ent] <= req_wdata;
        if (sel_itr) itr_q[ent] <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_valid <= 1'b0; flush_all <= 1'b0; flush_page <= '0;
    end else begin
      flush_valid <= 1'b0;
      if (wr && sel_sr && |((sr_q ^ req_wdata) & MODE_MASK)) begin
        flush_valid <= 1'b1; flush_all <= 1'b1;
      end else if (wr && sel_dmr && !req_wdata[0]) begin
        flush_valid <= 1'b1; flush_all <= 1'b0;
        flush_page  <= dmr_q[ent][DW-1:PAGE_SHIFT];
      end else if (wr && sel_imr && !req_wdata[0]) begin
        flush_valid <= 1'b1; flush_all <= 1'b0;
        flush_page  <= imr_q[ent][DW-1:PAGE_SHIFT];
      end
    end
  end

  always_comb begin
    rd_data = req_rd;
    if      (req_addr == spr(0, 0))  rd_data = vr_q & VER_MASK;
    else if (req_addr == spr(0, 1))  rd_data = UNIT_PRESENT;
    else if (req_addr == spr(0, 2))  rd_data = CPU_CFG;
    else if (req_addr == spr(0, 3))  rd_data = DMMU_CFG;
    else if (req_addr == spr(0, 4))  rd_data = IMMU_CFG;
    else if (req_addr == spr(0, 16)) rd_data = npc_q;
    else if (sel_sr)                 rd_data = sr_q;
    else if (req_addr == spr(0, 18)) rd_data = ppc_q;
    else if (req_addr == spr(0, 32)) rd_data = epc_q;
    else if (req_addr == spr(0, 48)) rd_data = eear_q;
    else if (req_addr == spr(0, 64)) rd_data = esr_q;
    else if (sel_dmr)                rd_data = dmr_q[ent];
    else if (sel_dtr)                rd_data = dtr_q[ent];
    else if (sel_imr)                rd_data = imr_q[ent];
    else if (sel_itr)                rd_data = itr_q[ent];
    else if (sel_pmask)              rd_data = pmask_q;
    else if (sel_pstat)              rd_data = pstat_q;
  end

  assert_fo_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_sr) |=> sr_q[FO]);
  assert_flush_follows_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(wr));
  assert_flush_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (!flush_valid || $past(wr)));
  assert_full_flush_from_sr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && flush_all) |-> $past(sel_sr));
  assert_mask_never_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pmask_q & $past(pmask_q)) == $past(pmask_q)));
  assert_status_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_pstat) |=> ((pstat_q & $past(req_wdata) & ~$past(irq_set)) == '0));
endmodule

// File: tb/spr_access_unit_tb.sv
`timescale 1ns/1ps
module spr_access_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0, req_rd = '0, irq_set = '0;
  logic [31:0] rd_data;
  logic flush_valid, flush_all;
  logic [18:0] flush_page;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  spr_access_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rd(req_rd), .irq_set(irq_set),
    .rd_data(rd_data), .flush_valid(flush_valid), .flush_all(flush_all), .flush_page(flush_page));

  typedef struct packed {
    logic we; logic [15:0] addr; logic [31:0] wd; logic [31:0] rd; logic [31:0] exp;
    logic fl; logic fa; logic [18:0] pg; logic [3:0] rq;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0011, 32'h0, 32'h55, 32'h0000_8001, 1'b0, 1'b0, 19'h0, 4'd12},     // R12
    '{1'b0, 16'h0001, 32'h0, 32'h55, 32'h0000_0019, 1'b0, 1'b0, 19'h0, 4'd1},      // R1
    '{1'b0, 16'h0002, 32'h0, 32'h55, 32'h0000_0020, 1'b0, 1'b0, 19'h0, 4'd1},      // R1
    '{1'b0, 16'h0003, 32'h0, 32'h55, 32'h0000_001A, 1'b0, 1'b0, 19'h0, 4'd1},      // R1
    '{1'b0, 16'h0004, 32'h0, 32'h55, 32'h0000_001C, 1'b0, 1'b0, 19'h0, 4'd1},      // R1
    '{1'b1, 16'h0011, 32'h1, 32'h0,  32'h0,         1'b0, 1'b0, 19'h0, 4'd3},      // R3
    '{1'b0, 16'h0011, 32'h0, 32'h0,  32'h0000_8001, 1'b0, 1'b0, 19'h0, 4'd3},      // R3
    '{1'b1, 16'h0011, 32'h20, 32'h0, 32'h0,         1'b1, 1'b1, 19'h0, 4'd4},      // R4
    '{1'b0, 16'h0011, 32'h0, 32'h0,  32'h0000_8020, 1'b0, 1'b0, 19'h0, 4'd11},     // R11
    '{1'b1, 16'h0011, 32'h8021, 32'h0, 32'h0,       1'b1, 1'b1, 19'h0, 4'd4},      // R4
    '{1'b1, 16'h0011, 32'h8021, 32'h0, 32'h0,       1'b0, 1'b0, 19'h0, 4'd4},      // R4
    '{1'b1, 16'h0A03, 32'h1234_6001, 32'h0, 32'h0,  1'b0, 1'b0, 19'h0, 4'd5},      // R5
    '{1'b0, 16'h0A03, 32'h0, 32'h0, 32'h1234_6001,  1'b0, 1'b0, 19'h0, 4'd5},      // R5
    '{1'b1, 16'h0A03, 32'h0, 32'h0, 32'h0,          1'b1, 1'b0, 19'h091A3, 4'd6},  // R6
    '{1'b0, 16'h0A03, 32'h0, 32'h7, 32'h0,          1'b0, 1'b0, 19'h0, 4'd6},      // R6
    '{1'b1, 16'h1285, 32'hCAFE_0000, 32'h0, 32'h0,  1'b0, 1'b0, 19'h0, 4'd5},      // R5
    '{1'b0, 16'h1285, 32'h0, 32'h0, 32'hCAFE_0000,  1'b0, 1'b0, 19'h0, 4'd5},      // R5
    '{1'b0, 16'h0A85, 32'h0, 32'h9, 32'h0,          1'b0, 1'b0, 19'h0, 4'd5},      // R5
    '{1'b1, 16'h1202, 32'h8000_2001, 32'h0, 32'h0,  1'b0, 1'b0, 19'h0, 4'd5},      // R5
    '{1'b1, 16'h1202, 32'h2, 32'h0, 32'h0,          1'b1, 1'b0, 19'h40001, 4'd6},  // R6
    '{1'b1, 16'h0B00, 32'hFFFF_FFFF, 32'h0, 32'h0,  1'b0, 1'b0, 19'h0, 4'd7},      // R7
    '{1'b0, 16'h0B00, 32'h0, 32'h0BAD_0001, 32'h0BAD_0001, 1'b0, 1'b0, 19'h0, 4'd7}, // R7
    '{1'b0, 16'h0A00, 32'h0, 32'h1, 32'h0,          1'b0, 1'b0, 19'h0, 4'd7},      // R7
    '{1'b1, 16'h4800, 32'h0F, 32'h0, 32'h0,         1'b0, 1'b0, 19'h0, 4'd8},      // R8
    '{1'b1, 16'h4800, 32'hF0, 32'h0, 32'h0,         1'b0, 1'b0, 19'h0, 4'd8},      // R8
    '{1'b0, 16'h4800, 32'h0, 32'h0, 32'hFF,         1'b0, 1'b0, 19'h0, 4'd8},      // R8
    '{1'b1, 16'h4800, 32'h0, 32'h0, 32'h0,          1'b0, 1'b0, 19'h0, 4'd8},      // R8
    '{1'b0, 16'h4800, 32'h0, 32'h0, 32'hFF,         1'b0, 1'b0, 19'h0, 4'd8},      // R8
    '{1'b1, 16'h0000, 32'hDEAD_BEEF, 32'h0, 32'h0,  1'b0, 1'b0, 19'h0, 4'd2},      // R2
    '{1'b0, 16'h0000, 32'h0, 32'h0, 32'hDE00_0000,  1'b0, 1'b0, 19'h0, 4'd2},      // R2
    '{1'b0, 16'h5000, 32'h0, 32'h1357, 32'h1357,    1'b0, 1'b0, 19'h0, 4'd10},     // R10
    '{1'b1, 16'h0020, 32'hAAAA_5555, 32'h0, 32'h0,  1'b0, 1'b0, 19'h0, 4'd1},      // R1
    '{1'b0, 16'h0020, 32'h0, 32'h0, 32'hAAAA_5555,  1'b0, 1'b0, 19'h0, 4'd1},      // R1
    '{1'b1, 16'h0002, 32'hFFFF_FFFF, 32'h0, 32'h0,  1'b0, 1'b0, 19'h0, 4'd1},      // R1
    '{1'b0, 16'h0002, 32'h0, 32'h0, 32'h0000_0020,  1'b0, 1'b0, 19'h0, 4'd1}       // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read(input logic [15:0] a, input logic [31:0] rd, input logic [31:0] exp, input string req);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_rd = rd;
    #1 check(req, rd_data, exp);
    @(negedge clk);
  endtask

  task automatic write(input logic [15:0] a, input logic [31:0] wd);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_we = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", {31'b0, flush_valid}, 32'h0);
    read(16'h4800, 32'h3, 32'h0, "R12");
    read(16'h0000, 32'h3, 32'h1200_0000, "R12");

    for (int i = 0; i < NV; i++) begin
      req_valid = 1'b1; req_we = VECS[i].we; req_addr = VECS[i].addr;
      req_wdata = VECS[i].wd; req_rd = VECS[i].rd;
      #1;
      if (!VECS[i].we) check($sformatf("R%0d", VECS[i].rq), rd_data, VECS[i].exp);
      @(negedge clk);
      check($sformatf("R%0d flush", VECS[i].rq), {31'b0, flush_valid}, {31'b0, VECS[i].fl});
      if (VECS[i].fl) check($sformatf("R%0d kind", VECS[i].rq), {31'b0, flush_all}, {31'b0, VECS[i].fa});
      if (VECS[i].fl && !VECS[i].fa) check($sformatf("R%0d page", VECS[i].rq), {13'b0, flush_page}, {13'b0, VECS[i].pg});
    end
    req_valid = 1'b0; req_we = 1'b0;

    // R9: pending set, write-one-to-clear, set wins on collision
    irq_set = 32'hF0; @(negedge clk); irq_set = 32'h0;
    read(16'h4802, 32'h0, 32'hF0, "R9");
    write(16'h4802, 32'h30);
    read(16'h4802, 32'h0, 32'hC0, "R9");
    irq_set = 32'h40;
    write(16'h4802, 32'h40);
    irq_set = 32'h0;
    read(16'h4802, 32'h0, 32'hC0, "R9");

    // R7: way-1 translate write leaves way-0 translate untouched
    write(16'h0B85, 32'h1234_5678);
    read(16'h0A85, 32'h0, 32'h0, "R7");

    // R12: reset in mid-run
    req_valid = 1'b0;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    read(16'h4800, 32'h1, 32'h0, "R12");
    read(16'h0011, 32'h1, 32'h0000_8001, "R12");
    read(16'h0A03, 32'h1, 32'h0, "R12");
    req_valid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule